// File: doc/BRIEF.md
# Three-Channel Timer Compare/Capture Pin Controller

This block gives three timer channels each a 16-bit free-running counter and one general-purpose register. A small 3-bit control code per channel picks the role of that register. As a compare register, it drives the channel's A pin when the counter reaches it: the pin can stay as it is, go low, go high or invert. As a capture register, it stores the counter value when the channel's input pin shows a rising edge, a falling edge or either edge. The last channel cannot invert its pin. For that channel, the invert code drives the pin high instead.

A write-only level preset register sets the starting levels of every channel's A and B pins. A channel takes a new preset only while its start bit is low, so software loads the levels first and then starts the counter. Register access uses a flat bus with a write strobe, a 3-bit address and combinational read data. Each channel has one start input that counts up its counter.

Top module: `tmr_io_ctrl`

## Requirements
- R1: While a channel's start bit is 1, its counter increments on every clock and wraps from 0xFFFF to 0x0000. While the start bit is 0, the counter holds its value.
- R2: Control codes 000, 001, 010 and 011 make the register a compare register. On a match the A pin is left unchanged (000), driven 0 (001), driven 1 (010) or inverted (011). This applies on channels 0 and 1.
- R3: On channel 2, code 011 drives the A pin to 1 on every match. The pin never falls.
- R4: A match is a cycle in which the channel is running and its counter equals its register. The A pin takes its new level at the clock edge that ends that cycle.
- R5: Code 100 captures on a rising input edge, 101 on a falling edge, and 110 or 111 on either edge. The input passes two synchroniser flops. The stored value is the counter value in the cycle that follows the second clock edge after the input changes.
- R6: While a channel is in a capture code (bit 2 set), counter matches never change its A pin.
- R7: The preset register is written at address 0. Bit 2c is channel c's A pin level and bit 2c+1 is its B pin level. A pin B always shows its stored bit. An accepted write loads the A pin at the write edge.
- R8: A preset write leaves a running channel's two bits, and its A pin, unchanged. Bits of stopped channels in the same write are still accepted.
- R9: Address 0 reads 0xFFFF. After reset the preset holds 0xC0, so all A and B pins are 0.
- R10: Addresses 1 to 3 are the control registers of channels 0 to 2. They read the code in bits 2:0, a 1 in bit 3 and 0 above. Addresses 4 to 6 read and write the channel registers, and address 7 reads 0.
- R11: After reset every counter is 0, every channel register is 0xFFFF and every control code is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 3 | Per-channel start bits |
| cap_in | input | 3 | Per-channel capture input pins (asynchronous) |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_a | output | 3 | Per-channel A pin level |
| pin_b | output | 3 | Per-channel B pin level |

## Verification
The bench times compare matches to the exact cycle. A design that compared the next counter value, or that registered the match once more, would move the pin one cycle off. Invert mode is driven twice on channels 1 and 2. This exposes a channel 2 that still inverts, or a channel 1 that was wrongly made non-inverting. One second match needs a full counter wrap, so a counter that saturated or skipped values never matches again. Capture values are checked against the two-flop synchroniser delay and against a stopped counter. Preset writes during running are checked at the pins, to catch a lock that covers the wrong bits or no bits at all.

// File: rtl/tmr_io_pkg.sv
package tmr_io_pkg;
    localparam int CH_N   = 3;
    localparam int CNT_W  = 16;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;
    localparam int LVL_W  = 2 * CH_N;

    localparam logic [ADDR_W-1:0] ADDR_LVL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTL0 = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_GRA0 = 3'd4;
    localparam logic [7:0]        LVL_RST   = 8'hC0;

    typedef enum logic [2:0] {
        M_NONE  = 3'b000,
        M_LOW   = 3'b001,
        M_HIGH  = 3'b010,
        M_TOGL  = 3'b011,
        M_CAP_R = 3'b100,
        M_CAP_F = 3'b101,
        M_CAP_A = 3'b110,
        M_CAP_B = 3'b111
    } gra_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] gra;
        gra_mode_e        mode;
        logic [2:0]       sync;
        logic             pin;
    } chan_st_t;
endpackage

// File: rtl/tmr_io_lvl.sv
module tmr_io_lvl
    import tmr_io_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [LVL_W-1:0] wdata_i,
    input  logic [CH_N-1:0]  run_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [CH_N-1:0]  load_o
);
    logic [LVL_W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        for (int c = 0; c < CH_N; c++) begin
            load_o[c] = we_i && !run_i[c];
            if (load_o[c]) begin
                lvl_d[2*c]   = wdata_i[2*c];
                lvl_d[2*c+1] = wdata_i[2*c+1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_RST[LVL_W-1:0];
        else        lvl_q <= lvl_d;
    end

    assign lvl_o = lvl_q;

    for (genvar c = 0; c < CH_N; c++) begin : g_lock
        AST_LVL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            run_i[c] |=> $stable(lvl_q[2*c+1 -: 2])); // R8
    end
endmodule

// File: rtl/tmr_io_chan.sv
module tmr_io_chan
    import tmr_io_pkg::*;
#(
    parameter bit TOGGLE_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cap_i,
    input  logic             ctl_we_i,
    input  logic             gra_we_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             lvl_load_i,
    input  logic             lvl_a_i,
    output logic [2:0]       mode_o,
    output logic [CNT_W-1:0] gra_o,
    output logic             pin_o
);
    chan_st_t st_d, st_q;
    logic cmp_hit, cap_hit, rise, fall, tog_val;

    if (TOGGLE_OK) begin : g_tog
        assign tog_val = ~st_q.pin;
    end else begin : g_high
        assign tog_val = 1'b1;
    end

    always_comb begin
        st_d    = st_q;
        rise    = st_q.sync[1] && !st_q.sync[2];
        fall    = !st_q.sync[1] && st_q.sync[2];
        cmp_hit = run_i && !st_q.mode[2] && (st_q.cnt == st_q.gra);
        cap_hit = st_q.mode[2] &&
                  (st_q.mode[1] ? (rise || fall) : (st_q.mode[0] ? fall : rise));

        st_d.sync = {st_q.sync[1:0], cap_i};
        if (run_i)    st_d.cnt  = st_q.cnt + 1'b1;
        if (ctl_we_i) st_d.mode = gra_mode_e'(wdata_i[2:0]);
        if (gra_we_i) st_d.gra  = wdata_i[CNT_W-1:0];
        if (cap_hit)  st_d.gra  = st_q.cnt;

        if (lvl_load_i) begin
            st_d.pin = lvl_a_i;
        end else if (cmp_hit) begin
            case (st_q.mode)
                M_LOW:   st_d.pin = 1'b0;
                M_HIGH:  st_d.pin = 1'b1;
                M_TOGL:  st_d.pin = tog_val;
                default: st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.gra  <= '1;
            st_q.mode <= M_NONE;
            st_q.sync <= '0;
            st_q.pin  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign gra_o  = st_q.gra;
    assign pin_o  = st_q.pin;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.cnt)); // R1
    AST_CAP_PIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode[2] && !lvl_load_i) |=> $stable(st_q.pin)); // R6
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_load_i |=> st_q.pin == $past(lvl_a_i)); // R7

    if (!TOGGLE_OK) begin : g_chk_high
        AST_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.mode == M_TOGL && st_q.pin && !lvl_load_i) |=> st_q.pin); // R3
    end
endmodule

// File: rtl/tmr_io_ctrl.sv
module tmr_io_ctrl
    import tmr_io_pkg::*;
#(
    parameter logic [CH_N-1:0] TOG_MASK = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   run,
    input  logic [CH_N-1:0]   cap_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CH_N-1:0]   pin_a,
    output logic [CH_N-1:0]   pin_b
);
    logic [LVL_W-1:0] lvl;
    logic [CH_N-1:0]  lvl_load;
    logic [2:0]       mode_w [CH_N];
    logic [CNT_W-1:0] gra_w  [CH_N];

    tmr_io_lvl u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we && bus_addr == ADDR_LVL),
        .wdata_i (bus_wdata[LVL_W-1:0]),
        .run_i   (run),
        .lvl_o   (lvl),
        .load_o  (lvl_load)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL0 + c);
        localparam logic [ADDR_W-1:0] A_GRA = ADDR_W'(ADDR_GRA0 + c);

        tmr_io_chan #(.TOGGLE_OK(TOG_MASK[c])) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (run[c]),
            .cap_i      (cap_in[c]),
            .ctl_we_i   (bus_we && bus_addr == A_CTL),
            .gra_we_i   (bus_we && bus_addr == A_GRA),
            .wdata_i    (bus_wdata),
            .lvl_load_i (lvl_load[c]),
            .lvl_a_i    (bus_wdata[2*c]),
            .mode_o     (mode_w[c]),
            .gra_o      (gra_w[c]),
            .pin_o      (pin_a[c])
        );

        assign pin_b[c] = lvl[2*c+1];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_LVL) bus_rdata = '1;
        for (int c = 0; c < CH_N; c++) begin
            if (bus_addr == ADDR_W'(ADDR_CTL0 + c)) bus_rdata = BUS_W'({1'b1, mode_w[c]});
            if (bus_addr == ADDR_W'(ADDR_GRA0 + c)) bus_rdata = BUS_W'(gra_w[c]);
        end
    end
endmodule

// File: tb/tmr_io_ctrl_test.sv
module tmr_io_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  run = '0;
    logic [2:0]  cap_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  pin_a, pin_b;

    int checks = 0;
    int errors = 0;
    logic [15:0] cm [3];

    // entries: {mode[2:0], preset level, expected pin after match}
    localparam logic [4:0] CMP_VEC [5] = '{
        {3'b000, 1'b1, 1'b1},
        {3'b001, 1'b1, 1'b0},
        {3'b010, 1'b0, 1'b1},
        {3'b011, 1'b0, 1'b1},
        {3'b011, 1'b1, 1'b0}
    };

    tmr_io_ctrl uut (
        .clk(clk), .rst_n(rst_n), .run(run), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_a(pin_a), .pin_b(pin_b)
    );

    always #5 clk = ~clk;

    // reference counters per R1
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) cm[c] <= '0;
        end else begin
            for (int c = 0; c < 3; c++) if (run[c]) cm[c] <= cm[c] + 16'd1;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic match_at(input int ch, input logic [15:0] tgt,
                            input logic bef, input logic aft, input string req);
        while (cm[ch] !== tgt) @(negedge clk);
        chk(req, 16'(pin_a[ch]), 16'(bef));
        @(negedge clk);
        chk(req, 16'(pin_a[ch]), 16'(aft));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, tgt, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 R11: reset state
        chk("R9 reset pin_a", 16'(pin_a), 16'h0);
        chk("R9 reset pin_b", 16'(pin_b), 16'h0);
        rd(3'd0, v); chk("R9 preset reads ones", v, 16'hFFFF);
        rd(3'd1, v); chk("R11 reset code", v, 16'h0008);
        rd(3'd4, v); chk("R11 reset register", v, 16'hFFFF);
        rd(3'd7, v); chk("R10 unused address", v, 16'h0000);

        // R10: control readback, bit 3 always set
        for (int m = 0; m < 8; m++) begin
            wr(3'd3, 16'hFFF0 | 16'(m));
            rd(3'd3, v); chk("R10 control readback", v, 16'h0008 | 16'(m));
        end

        // R2 R4 R7: compare table on channel 0
        for (int i = 0; i < 5; i++) begin
            run = 3'b000;
            wr(3'd1, 16'(CMP_VEC[i][4:2]));
            wr(3'd0, 16'(CMP_VEC[i][1]));
            chk("R7 preset loads A0", 16'(pin_a[0]), 16'(CMP_VEC[i][1]));
            tgt = cm[0] + 16'd6;
            wr(3'd4, tgt);
            run = 3'b001;
            match_at(0, tgt, CMP_VEC[i][1], CMP_VEC[i][0], "R2 R4 compare");
        end

        // R8: channel 0 running, others stopped
        wr(3'd0, 16'h003F);
        chk("R8 running B0 unchanged", 16'(pin_b[0]), 16'h0);
        chk("R8 running A0 unchanged", 16'(pin_a[0]), 16'h0);
        chk("R8 stopped bits accepted", {13'h0, pin_a[2:1], pin_b[1]}, 16'h0007);
        chk("R7 B2 follows preset", 16'(pin_b[2]), 16'h1);
        run = 3'b000;
        wr(3'd0, 16'h0000);

        // R3: channel 2 code 011 drives high, never falls
        wr(3'd3, 16'h0003);
        run = 3'b100;
        tgt = cm[2] + 16'd6; wr(3'd6, tgt);
        match_at(2, tgt, 1'b0, 1'b1, "R3 first match");
        tgt = cm[2] + 16'd6; wr(3'd6, tgt);
        match_at(2, tgt, 1'b1, 1'b1, "R3 second match");
        run = 3'b000;

        // R1 R2: channel 1 toggles, again after a full wrap
        wr(3'd2, 16'h0003);
        run = 3'b010;
        tgt = cm[1] + 16'd6; wr(3'd5, tgt);
        match_at(1, tgt, 1'b0, 1'b1, "R2 toggle up");
        match_at(1, tgt, 1'b1, 1'b0, "R1 wrap toggle down");
        run = 3'b000;

        // R5 R6: capture on channel 2, pin A2 preset to 1
        wr(3'd0, 16'h0010);
        wr(3'd3, 16'h0004);
        run = 3'b100;
        repeat (3) @(negedge clk);
        cap_in[2] = 1'b1; exp = cm[2] + 16'd2;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R5 rising capture", v, exp);
        cap_in[2] = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R5 rising mode ignores fall", v, exp);

        wr(3'd3, 16'h0005);
        cap_in[2] = 1'b1;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R5 falling mode ignores rise", v, exp);
        cap_in[2] = 1'b0; exp = cm[2] + 16'd2;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R5 falling capture", v, exp);

        wr(3'd3, 16'h0006);
        cap_in[2] = 1'b1; exp = cm[2] + 16'd2;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R5 both-edge rise", v, exp);
        wr(3'd3, 16'h0007);
        cap_in[2] = 1'b0; exp = cm[2] + 16'd2;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R5 both-edge fall", v, exp);

        // R1 hold: capture from a stopped counter
        run = 3'b000;
        repeat (2) @(negedge clk);
        exp = cm[2];
        cap_in[2] = 1'b1;
        repeat (5) @(negedge clk);
        rd(3'd6, v); chk("R1 stopped counter holds", v, exp);
        chk("R6 capture keeps pin A2", 16'(pin_a[2]), 16'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule